// File: doc/BRIEF.md
# Shared-Exponent Block Quantizer

This block turns a group of 32 single-precision floating-point numbers into a compact integer block. The group gets one power-of-two scale, held as an 8-bit biased exponent code with no mantissa, and every value becomes a signed 8-bit integer. All lanes arrive together on one wide bus, qualified by a valid strobe. The block returns one packed 264-bit word, qualified by its own valid strobe.

Inside, a comparator tree finds the largest magnitude in the group. The scale code is computed from that maximum. Each lane then shifts its significand by the gap between its own exponent and the scale, and rounds the result. Infinity and NaN inputs put a reserved code in the scale field. A group that holds only zeros and subnormals yields an all-zero word. An optional output register adds one cycle of latency; without it the path is purely combinational.

Top module: `mxq_block_quant`

## Requirements
- R1: In the output word the scale code occupies bits [263:256]. The element for lane i occupies bits [8i+7:8i], so lane 0 sits in the lowest byte. Input lane i occupies in_data[32i+31:32i] as an IEEE single (sign in bit 31, exponent in bits 30:23, fraction in bits 22:0).
- R2: Let c be the scale code for a block with at least one normal input and no special input. The code means a scale of 2^(c-127). The scale is the smallest power of two 2^k for which 127·2^k is at least the largest input magnitude, and c = k + 127.
- R3: Each element is the two's-complement 8-bit value of its input divided by the scale, rounded to the nearest integer. An exact tie goes to the even neighbour.
- R4: Elements always stay within -127..+127. The code 0x80 never appears in an element field.
- R5: A block whose rule from R2 would give a code below 1 uses code 1 instead, a scale of 2^-126. Its elements follow R3 against that scale.
- R6: If any lane has an exponent field of all ones (infinity or NaN), the scale code is 0xFF and every element is 0.
- R7: Inputs with an exponent field of zero (zero and subnormals) are treated as zero and give element 0. A block made only of such inputs gives scale code 0 with all elements 0.
- R8: With OUT_REG=1, out_valid repeats in_valid one cycle later and out_word carries the result for the block captured on that edge. Blocks may arrive on back-to-back cycles. With OUT_REG=0, out_valid and out_word follow the inputs in the same cycle.
- R9: While rst_n is low at a clock edge, the registered variant clears out_valid and out_word to zero.
- R10: With OUT_REG=1, out_word keeps its last value on every cycle in which in_valid was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_data as a block to convert |
| in_data | input | 1024 | 32 single-precision lanes, lane 0 lowest |
| out_valid | output | 1 | Marks out_word as a fresh result |
| out_word | output | 264 | Scale code on top, then 32 signed 8-bit elements |

## Verification
The bench builds two copies of the block with 32 lanes and 8-bit elements. One uses the output register and the other does not. The registered copy brings within reach the one-cycle latency, back-to-back streaming, reset clearing and holding the output across idle cycles. The combinational copy is checked in the same cycle against the same expected word. Directed blocks cover rounding ties, the scale bump when the maximum's fraction lies just above 63/64, the floor scale code for the smallest normals, the largest finite input, infinity, NaN and subnormal flushing. Random blocks with narrow and wide exponent spreads cover the rest.

// File: rtl/mxq_pkg.sv
// Package: shared constants and types for the block quantizer.
// Assumes IEEE single-precision inputs and an 8-bit biased exponent scale code.
package mxq_pkg;

    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int KEY_W   = EXP_W + MAN_W;
    localparam int SCALE_W = 8;

    localparam logic [SCALE_W-1:0] SCALE_NAN  = 8'hFF;
    localparam logic [SCALE_W-1:0] SCALE_ZERO = 8'h00;
    localparam logic [SCALE_W-1:0] SCALE_MIN  = 8'h01;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp32_t;

endpackage

// File: rtl/mxq_max_tree.sv
// Module: balanced comparator tree returning the largest unsigned key.
// Assumes LANES is a power of two; keys are packed with lane 0 lowest.
module mxq_max_tree #(
    parameter int LANES = 32,
    parameter int W     = 31
) (
    input  logic [LANES*W-1:0] keys,
    output logic [W-1:0]       max_key
);

    localparam int LEVELS = $clog2(LANES);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int CNT = LANES >> l;
        logic [W-1:0] v [CNT];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < CNT; i++) begin : g_in
                // leaf: take one lane key
                assign v[i] = keys[i*W +: W];
            end
        end else begin : g_node
            for (genvar j = 0; j < CNT; j++) begin : g_cmp
                // node: keep the larger of two children
                assign v[j] = (g_lvl[l-1].v[2*j] >= g_lvl[l-1].v[2*j+1])
                            ? g_lvl[l-1].v[2*j] : g_lvl[l-1].v[2*j+1];
            end
        end
    end

    assign max_key = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/mxq_scale_gen.sv
// Module: derives the biased power-of-two scale code from the largest key.
// Assumes max_key is {exponent, fraction} of the largest normal lane (0 if none).
// The scale 2^k is the smallest with (2^(ELEM_W-1)-1)*2^k >= max magnitude.
module mxq_scale_gen
    import mxq_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  logic [KEY_W-1:0]   max_key,
    input  logic               any_normal,
    input  logic               any_special,
    output logic [SCALE_W-1:0] scale_code
);

    localparam int SHIFT = ELEM_W - 2;
    localparam logic [MAN_W-1:0] THRESH = MAN_W'(((1 << SHIFT) - 1) << (MAN_W - SHIFT));
    localparam logic [EXP_W:0]   SHIFT_W = (EXP_W+1)'(SHIFT);

    logic [EXP_W-1:0] emax;
    logic [MAN_W-1:0] mmax;
    logic             bump;
    logic [EXP_W:0]   raised;

    // split the maximum and decide whether its fraction needs one more power
    always_comb begin
        emax   = max_key[KEY_W-1:MAN_W];
        mmax   = max_key[MAN_W-1:0];
        bump   = (mmax > THRESH);
        raised = (EXP_W+1)'(emax) + (EXP_W+1)'(bump);
    end

    // select the code: reserved, empty block, floor value or computed value
    always_comb begin
        if (any_special) begin
            scale_code = SCALE_NAN;
        end else if (!any_normal) begin
            scale_code = SCALE_ZERO;
        end else if (raised <= SHIFT_W) begin
            scale_code = SCALE_MIN;
        end else begin
            scale_code = SCALE_W'(raised - SHIFT_W);
        end
    end

endmodule

// File: rtl/mxq_lane_quant.sv
// Module: one lane of shift, round-half-even and symmetric clamp.
// Assumes the lane exponent never exceeds the block maximum, so the
// right shift amount is always at least the fraction width minus a few bits.
module mxq_lane_quant
    import mxq_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  fp32_t              lane_in,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic               block_ok,
    output logic [ELEM_W-1:0]  elem
);

    localparam int SIG_W  = MAN_W + 1;
    localparam int WIDE_W = 2 * SIG_W;
    localparam int MAG_W  = SIG_W + 1;
    localparam int RSH_W  = 10;
    localparam int QMAX   = (1 << (ELEM_W - 1)) - 1;
    localparam logic [MAG_W-1:0] QMAX_M    = MAG_W'(QMAX);
    localparam logic [RSH_W-1:0] RSH_LIMIT = RSH_W'(MAN_W + 2);

    logic [SIG_W-1:0]  sig;
    logic [RSH_W-1:0]  rsh;
    logic [WIDE_W-1:0] wide;
    logic [SIG_W-1:0]  q;
    logic              guard;
    logic              sticky;
    logic              round_up;
    logic [MAG_W-1:0]  mag;
    logic [ELEM_W-1:0] clamped;
    logic              live;

    // align the significand to the shared scale and keep guard and sticky
    always_comb begin
        sig    = {1'b1, lane_in.man};
        rsh    = RSH_W'(MAN_W) + RSH_W'(scale_code) - RSH_W'(lane_in.exp);
        wide   = {sig, SIG_W'(0)} >> rsh;
        q      = wide[WIDE_W-1:SIG_W];
        guard  = wide[SIG_W-1];
        sticky = |wide[SIG_W-2:0];
    end

    // round to nearest, ties to even, then clamp to the symmetric limit
    always_comb begin
        round_up = guard & (sticky | q[0]);
        mag      = {1'b0, q} + MAG_W'(round_up);
        clamped  = (mag > QMAX_M) ? ELEM_W'(QMAX) : mag[ELEM_W-1:0];
    end

    // apply sign, and zero the lane for flushed inputs or dead blocks
    always_comb begin
        live = block_ok && (lane_in.exp != '0) && (rsh <= RSH_LIMIT);
        if (!live) begin
            elem = '0;
        end else if (lane_in.sign) begin
            elem = ~clamped + ELEM_W'(1);
        end else begin
            elem = clamped;
        end
    end

endmodule

// File: rtl/mxq_block_quant.sv
// Module: top of the shared-exponent block quantizer.
// Classifies lanes, finds the block maximum, builds the scale code and
// quantizes every lane; an optional register stage adds one cycle.
// Assumes LANES is a power of two and rst_n is synchronous, active low.
module mxq_block_quant
    import mxq_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int ELEM_W  = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [LANES*FP_W-1:0]             in_data,
    output logic                              out_valid,
    output logic [SCALE_W+LANES*ELEM_W-1:0]   out_word
);

    localparam int ELEMS_W = LANES * ELEM_W;
    localparam int OUT_W   = SCALE_W + ELEMS_W;
    localparam logic [ELEM_W-1:0] MIN_CODE = {1'b1, {(ELEM_W-1){1'b0}}};

    logic [LANES-1:0]       lane_special;
    logic [LANES-1:0]       lane_normal;
    logic [LANES*KEY_W-1:0] keys;
    logic [KEY_W-1:0]       max_key;
    logic                   any_special;
    logic                   any_normal;
    logic                   block_ok;
    logic [SCALE_W-1:0]     scale_code;
    logic [OUT_W-1:0]       comb_word;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fp32_t f;
        // unpack one lane and classify it
        assign f               = in_data[i*FP_W +: FP_W];
        assign lane_special[i] = &f.exp;
        assign lane_normal[i]  = (f.exp != '0) && !(&f.exp);
        assign keys[i*KEY_W +: KEY_W] = lane_normal[i] ? {f.exp, f.man} : '0;

        mxq_lane_quant #(.ELEM_W(ELEM_W)) u_lane (
            .lane_in    (f),
            .scale_code (scale_code),
            .block_ok   (block_ok),
            .elem       (comb_word[i*ELEM_W +: ELEM_W])
        );
    end

    // block-wide flags
    always_comb begin
        any_special = |lane_special;
        any_normal  = |lane_normal;
        block_ok    = any_normal & ~any_special;
    end

    mxq_max_tree #(.LANES(LANES), .W(KEY_W)) u_tree (
        .keys    (keys),
        .max_key (max_key)
    );

    mxq_scale_gen #(.ELEM_W(ELEM_W)) u_scale (
        .max_key     (max_key),
        .any_normal  (any_normal),
        .any_special (any_special),
        .scale_code  (scale_code)
    );

    assign comb_word[OUT_W-1 -: SCALE_W] = scale_code;

    if (OUT_REG) begin : g_reg
        // output stage: capture on valid, hold otherwise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_word  <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    out_word <= comb_word;
                end
            end
        end

        p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_word));
        p_reset_clear_r9: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && out_word == '0));
        p_live_scale_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (|lane_normal) && !(|lane_special))
            |=> (out_word[OUT_W-1 -: SCALE_W] != SCALE_ZERO &&
                 out_word[OUT_W-1 -: SCALE_W] != SCALE_NAN));
    end else begin : g_comb
        // output stage: pass straight through
        always_comb begin
            out_valid = in_valid;
            out_word  = comb_word;
        end
    end

    logic [LANES-1:0] out_is_min;
    logic [LANES-1:0] out_is_zero;
    for (genvar i = 0; i < LANES; i++) begin : g_watch
        // per-lane flags on the delivered word
        assign out_is_min[i]  = (out_word[i*ELEM_W +: ELEM_W] == MIN_CODE);
        assign out_is_zero[i] = (out_word[i*ELEM_W +: ELEM_W] == '0);
    end

    p_no_min_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_is_min == '0));
    p_nan_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[OUT_W-1 -: SCALE_W] == SCALE_NAN) |-> (&out_is_zero));
    p_empty_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[OUT_W-1 -: SCALE_W] == SCALE_ZERO) |-> (&out_is_zero));

endmodule

// File: tb/sim_mxq_block_quant.sv
// Scoreboard bench: the driver pushes model results, the monitor pops and compares.
module sim_mxq_block_quant;

    localparam int LANES = 32;
    localparam int IN_W  = LANES * 32;
    localparam int OUT_W = 8 + LANES * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             u0_valid, u1_valid;
    logic [OUT_W-1:0] u0_word, u1_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [OUT_W-1:0] qw [$];
    string            qt [$];
    logic [OUT_W-1:0] last_word = '0;
    real              vals [LANES];

    always #5 clk = ~clk;

    mxq_block_quant #(.LANES(LANES), .ELEM_W(8), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(u0_valid), .out_word(u0_word));

    mxq_block_quant #(.LANES(LANES), .ELEM_W(8), .OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(u1_valid), .out_word(u1_word));

    task automatic check(input bit ok, input string tag,
                         input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic real pow2(input int k);
        real p = 1.0;
        if (k >= 0) for (int n = 0; n < k; n++) p = p * 2.0;
        else        for (int n = 0; n < -k; n++) p = p / 2.0;
        return p;
    endfunction

    function automatic real f2r(input logic [31:0] b);
        real v;
        v = (1.0 + real'(b[22:0]) / 8388608.0) * pow2(int'(b[30:23]) - 127);
        return b[31] ? -v : v;
    endfunction

    // exact conversion for values with at most 24 significant bits
    function automatic logic [31:0] r2f(input real v);
        real a;
        int  e;
        logic [31:0] b;
        if (v == 0.0) return 32'h0;
        a = (v < 0.0) ? -v : v;
        e = 127;
        while (a >= 2.0) begin a = a / 2.0; e++; end
        while (a < 1.0)  begin a = a * 2.0; e--; end
        b[31]    = (v < 0.0);
        b[30:23] = 8'(e);
        b[22:0]  = 23'($rtoi((a - 1.0) * 8388608.0));
        return b;
    endfunction

    function automatic logic [IN_W-1:0] pack_vals();
        logic [IN_W-1:0] d;
        for (int i = 0; i < LANES; i++) d[i*32 +: 32] = r2f(vals[i]);
        return d;
    endfunction

    // reference model written from the requirements
    function automatic logic [OUT_W-1:0] model(input logic [IN_W-1:0] d);
        logic [OUT_W-1:0] w = '0;
        real v [LANES];
        real maxa = 0.0;
        real p, t, a, fr;
        int  k, n;
        bit  special = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            logic [31:0] b = d[i*32 +: 32];
            if (b[30:23] == 8'hFF) special = 1'b1;
            v[i] = (b[30:23] == 8'h00 || b[30:23] == 8'hFF) ? 0.0 : f2r(b);
            a = (v[i] < 0.0) ? -v[i] : v[i];
            if (a > maxa) maxa = a;
        end
        if (special) begin
            w[OUT_W-1 -: 8] = 8'hFF;
            return w;
        end
        if (maxa == 0.0) return w;
        k = -126;
        p = pow2(-126);
        while (127.0 * p < maxa) begin p = p * 2.0; k++; end
        w[OUT_W-1 -: 8] = 8'(k + 127);
        for (int i = 0; i < LANES; i++) begin
            t  = v[i] / p;
            a  = (t < 0.0) ? -t : t;
            n  = $rtoi($floor(a));
            fr = a - $floor(a);
            if (fr > 0.5 || (fr == 0.5 && (n % 2) == 1)) n++;
            if (n > 127) n = 127;
            if (t < 0.0) n = -n;
            w[i*8 +: 8] = 8'(n);
        end
        return w;
    endfunction

    function automatic logic [IN_W-1:0] rand_block(input bit wide_spread);
        logic [IN_W-1:0] d;
        for (int i = 0; i < LANES; i++) begin
            logic [31:0] b;
            b[31]    = 1'($urandom % 2);
            b[30:23] = wide_spread ? 8'(1 + $urandom % 254) : 8'(110 + $urandom % 30);
            b[22:0]  = 23'($urandom);
            if ($urandom % 8 == 0) b = 32'h0;
            d[i*32 +: 32] = b;
        end
        return d;
    endfunction

    task automatic clear_vals();
        for (int i = 0; i < LANES; i++) vals[i] = 0.0;
    endtask

    // driver: present one block, queue its expectation, check the unregistered copy
    task automatic send(input logic [IN_W-1:0] d, input string tag);
        logic [OUT_W-1:0] e;
        e = model(d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        qw.push_back(e);
        qt.push_back(tag);
        #1;
        check(u1_valid === 1'b1 && u1_word === e, {tag, " R8 same-cycle"}, u1_word, e);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = rand_block(1'b1);
        end
    endtask

    // monitor: compare delivered words against the queue, and idle holds
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (u0_valid) begin
                if (qw.size() == 0) begin
                    check(1'b0, "R8 unexpected valid", u0_word, '0);
                end else begin
                    logic [OUT_W-1:0] e;
                    string t;
                    e = qw.pop_front();
                    t = qt.pop_front();
                    check(u0_word === e, t, u0_word, e);
                    last_word = e;
                end
            end else begin
                check(u0_word === last_word, "R10 hold while idle", u0_word, last_word);
            end
        end
    end

    initial begin
        logic [IN_W-1:0] d;
        repeat (3) @(negedge clk);
        check(u0_valid === 1'b0 && u0_word === '0, "R9 reset state", u0_word, '0);
        rst_n = 1'b1;

        // ramp of integers, includes a zero lane
        for (int i = 0; i < LANES; i++) vals[i] = real'(i) - 16.0;
        send(pack_vals(), "R1 R2 R3 ramp");

        // rounding ties against a unit scale
        clear_vals();
        vals[0] = 127.0; vals[1] = 2.5; vals[2] = 3.5; vals[3] = -2.5;
        vals[4] = 0.5; vals[5] = 1.5; vals[6] = -0.5; vals[31] = -126.5;
        send(pack_vals(), "R3 ties to even");

        // symmetric limit
        clear_vals();
        vals[0] = -127.0; vals[1] = 126.75; vals[9] = -126.75;
        send(pack_vals(), "R4 symmetric clamp");

        // scale bump boundary: fraction exactly 63/64 and just above
        clear_vals();
        vals[0] = 1.984375; vals[1] = -0.75;
        send(pack_vals(), "R2 max at threshold");
        clear_vals();
        vals[0] = 1.98828125; vals[1] = -0.75;
        send(pack_vals(), "R2 R3 max above threshold");

        // NaN in one lane, infinity in another
        d = rand_block(1'b0);
        d[7*32 +: 32] = 32'h7FC00000;
        send(d, "R6 NaN lane");
        d = rand_block(1'b0);
        d[31*32 +: 32] = 32'hFF800000;
        send(d, "R6 infinity lane");
        idle(2);

        // zero, subnormal-only and mixed blocks
        send('0, "R7 all zero");
        d = '0;
        for (int i = 0; i < LANES; i++) d[i*32 +: 32] = {1'(i % 2), 8'h00, 23'(i * 1237 + 5)};
        send(d, "R7 subnormal only");
        for (int i = 0; i < LANES; i += 2) d[i*32 +: 32] = r2f(real'(i) * 0.25 - 3.0);
        send(d, "R7 R3 mixed subnormal");

        // smallest normals force the floor code
        d = '0;
        d[3*32 +: 32]  = 32'h00800000;
        d[4*32 +: 32]  = 32'h00C00000;
        d[5*32 +: 32]  = 32'h80A00000;
        d[6*32 +: 32]  = 32'h80000000;
        send(d, "R5 floor scale");

        // largest finite input
        d = rand_block(1'b0);
        d[0] = 1'b0;
        d[0*32 +: 32] = 32'h7F7FFFFF;
        send(d, "R2 R3 largest finite");
        idle(3);

        // random streams, back-to-back with gaps
        for (int b = 0; b < 40; b++) begin
            send(rand_block(b % 3 == 0), "R1 R2 R3 R4 R8 random");
            if (b % 7 == 6) idle(1 + b % 3);
        end
        idle(3);
        check(qw.size() == 0, "R8 all results delivered", OUT_W'(qw.size()), '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule